// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words as the clock master of a two-wire synchronous link. It generates the shift clock from an internal divider and samples one data line. Each word has 8 data bits, plus a ninth bit when that option is on, and arrives least significant bit first. Completed words go from the shift register into a two-entry receive queue. The host reads the queue through a pop strobe, and each pop brings the next byte and its ninth bit to the outputs together.

There are two ways to start reception. A one-shot request fetches a single word and then releases the clock. A level enable keeps words streaming for as long as it is held, and it overrides the one-shot request. If a word completes while both queue entries are still unread, that word is discarded and a sticky overrun flag is raised. The flag stops every later transfer into the queue. Only a falling edge of the continuous enable clears it.

Top module: `sync_master_rx`

## Requirements
- R1: The data line is sampled at the clock edge where the shift clock goes from high to low, and the first sampled bit is bit 0 of the word.
- R2: The shift clock is low whenever reception is inactive. While reception is active it toggles every `div_val + 1` clock cycles, beginning with a rising edge.
- R3: A pulse on `one_shot_req`, with `cont_en` low, receives exactly one word. `one_shot_busy` then drops and the shift clock stays low.
- R4: While `cont_en` is high, words are received back to back. If a one-shot request is also active, reception continues past the first word.
- R5: With `nine_bit_en` high a word has 9 bits, and the ninth sampled bit appears on `rd_bit9` together with its byte. With `nine_bit_en` low a word has 8 bits and `rd_bit9` reads 0.
- R6: The receive queue holds two words in arrival order. `rd_data`/`rd_bit9` show the oldest word. A one-cycle `rd_en` pops it. `data_avail` is high exactly while the queue is not empty.
- R7: A word that completes while the queue holds two words and is not being read sets `overrun` and is discarded. The words already in the queue are unchanged.
- R8: While `overrun` is high, no completed word enters the queue, even when the queue has room.
- R9: `overrun` stays set through reads and further words. It clears on the cycle after `cont_en` goes from high to low.
- R10: `irq` is high exactly when `data_avail` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | DIV_W | Shift clock half-period minus one, in clock cycles |
| nine_bit_en | input | 1 | Selects 9-bit words |
| one_shot_req | input | 1 | Pulse that requests one word |
| cont_en | input | 1 | Continuous reception enable; its falling edge clears overrun |
| irq_en | input | 1 | Interrupt enable |
| rx_sdata | input | 1 | Serial data line |
| rd_en | input | 1 | Pops the oldest queue entry |
| rx_sclk | output | 1 | Generated shift clock |
| rd_data | output | 8 | Oldest queued byte |
| rd_bit9 | output | 1 | Ninth bit belonging to `rd_data` |
| data_avail | output | 1 | Queue not empty |
| irq | output | 1 | Data-available interrupt |
| overrun | output | 1 | Sticky overrun error |
| one_shot_busy | output | 1 | One-shot request still pending |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and a two-entry queue. It sets the divider to 1 and to 2 at run time, so one bit takes only a few cycles and the clock period can be measured exactly. With a two-entry queue, an overrun needs only three unread words. This brings the drop-and-block path and its clearing within a short run. A bench-side slave places each bit on the line at the rising shift-clock edge. A word is therefore received correctly only if it is sampled at the falling edge.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int RX_DATA_W = 8;

    typedef struct packed {
        logic                 b9;
        logic [RX_DATA_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rx_clkgen.sv
module rx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div_val,
    output logic             sclk,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        fall_tick = 1'b0;
        if (!active) begin
            st_d = '0;
        end else if (st_q.cnt == div_val) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            fall_tick = st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk = st_q.sclk;

    // R2: inactive reception parks the clock low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sclk);

    // R2: the clock only changes after the divider limit is reached
    a_r2_toggle_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> ($past(!active) || ($past(st_q.cnt) == $past(div_val))));
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
    import rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     fall_tick,
    input  logic     sdata,
    input  logic     wide9,
    output logic     word_done,
    output rx_word_t word_out
);
    localparam int SH_W = RX_DATA_W + 1;
    localparam int CW   = $clog2(SH_W + 1);

    typedef struct packed {
        logic [CW-1:0]   bitn;
        logic [SH_W-1:0] sh;
    } sh_st_t;

    sh_st_t          st_d, st_q;
    logic [SH_W-1:0] assembled;
    logic [CW-1:0]   last_idx;

    always_comb begin
        last_idx                = wide9 ? CW'(RX_DATA_W) : CW'(RX_DATA_W - 1);
        assembled               = st_q.sh;
        assembled[st_q.bitn]    = sdata;
        st_d                    = st_q;
        word_done               = 1'b0;
        if (!active) begin
            st_d = '0;
        end else if (fall_tick) begin
            if (st_q.bitn == last_idx) begin
                word_done = 1'b1;
                st_d      = '0;
            end else begin
                st_d.sh   = assembled;
                st_d.bitn = st_q.bitn + 1'b1;
            end
        end
        word_out.data = assembled[RX_DATA_W-1:0];
        word_out.b9   = wide9 & assembled[RX_DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the bit counter never runs past the ninth bit position
    a_r5_bitn_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bitn <= CW'(RX_DATA_W));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t push_word,
    input  logic     pop,
    output rx_word_t head,
    output logic     full,
    output logic     not_empty,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_word_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [CW-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wp] = push_word;
            st_d.wp           = nxt(st_q.wp);
        end
        if (do_pop) st_d.rp = nxt(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head      = st_q.mem[st_q.rp];
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign not_empty = (st_q.cnt != '0);
    assign level     = st_q.cnt;

    // R6: occupancy never exceeds the queue depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R6: a pop on a non-empty queue with no push lowers the level by one
    a_r6_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && not_empty) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import rx_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div_val,
    input  logic                 nine_bit_en,
    input  logic                 one_shot_req,
    input  logic                 cont_en,
    input  logic                 irq_en,
    input  logic                 rx_sdata,
    input  logic                 rd_en,
    output logic                 rx_sclk,
    output logic [RX_DATA_W-1:0] rd_data,
    output logic                 rd_bit9,
    output logic                 data_avail,
    output logic                 irq,
    output logic                 overrun,
    output logic                 one_shot_busy
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic single;
        logic cont_prev;
        logic ovr;
    } ctl_st_t;

    ctl_st_t  ctl_d, ctl_q;
    logic     active, fall_tick, word_done, fifo_full, fifo_ne;
    logic     push, pop, ovr_set;
    rx_word_t word, head;
    logic [LW-1:0] level;

    assign active = cont_en | ctl_q.single;

    rx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .active(active), .div_val(div_val),
        .sclk(rx_sclk), .fall_tick(fall_tick)
    );

    rx_shifter u_shifter (
        .clk(clk), .rst_n(rst_n), .active(active), .fall_tick(fall_tick),
        .sdata(rx_sdata), .wide9(nine_bit_en),
        .word_done(word_done), .word_out(word)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_word(word), .pop(pop),
        .head(head), .full(fifo_full), .not_empty(fifo_ne), .level(level)
    );

    always_comb begin
        ctl_d   = ctl_q;
        pop     = rd_en && fifo_ne;
        push    = word_done && !ctl_q.ovr && (!fifo_full || pop);
        ovr_set = word_done && !ctl_q.ovr && fifo_full && !pop;
        if (ctl_q.single && word_done) ctl_d.single = 1'b0;
        else if (one_shot_req)         ctl_d.single = 1'b1;
        if (ctl_q.cont_prev && !cont_en) ctl_d.ovr = 1'b0;
        else if (ovr_set)                ctl_d.ovr = 1'b1;
        ctl_d.cont_prev = cont_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data       = head.data;
    assign rd_bit9       = head.b9;
    assign data_avail    = fifo_ne;
    assign irq           = fifo_ne & irq_en;
    assign overrun       = ctl_q.ovr;
    assign one_shot_busy = ctl_q.single;

    // R1: a word completes only at a falling shift-clock edge
    a_r1_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (rx_sclk ##1 !rx_sclk));

    // R7: completion into a full, unread queue raises overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && fifo_full && !rd_en && cont_en) |=> overrun);

    // R8: no queue growth while overrun is raised
    a_r8_no_fill_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (level <= $past(level)));

    // R9: overrun persists while the continuous enable is held
    a_r9_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && cont_en) |=> overrun);
endmodule

// File: tb/tb_sync_master_rx.sv
module tb_sync_master_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_val = 8'd1;
    logic       nine_bit_en = 1'b0, one_shot_req = 1'b0, cont_en = 1'b0;
    logic       irq_en = 1'b0, rx_sdata = 1'b0, rd_en = 1'b0;
    logic       rx_sclk, rd_bit9, data_avail, irq, overrun, one_shot_busy;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    int cyc = 0, fall_cnt = 0, last_rise = 0, rise_gap = 0;
    logic prev_sclk = 1'b0;
    bit   bitq[$];
    logic [8:0] expq[$];
    bit   done_flag = 0;

    always #4 clk = ~clk;

    sync_master_rx dut (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .nine_bit_en(nine_bit_en),
        .one_shot_req(one_shot_req), .cont_en(cont_en), .irq_en(irq_en),
        .rx_sdata(rx_sdata), .rd_en(rd_en), .rx_sclk(rx_sclk), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .data_avail(data_avail), .irq(irq), .overrun(overrun),
        .one_shot_busy(one_shot_busy)
    );

    // slave model: new bit on each rising shift-clock edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rx_sclk && !prev_sclk) begin
            rx_sdata  <= (bitq.size() != 0) ? bitq.pop_front() : 1'b0;
            rise_gap  <= cyc - last_rise;
            last_rise <= cyc;
        end
        if (!rx_sclk && prev_sclk) fall_cnt <= fall_cnt + 1;
        prev_sclk <= rx_sclk;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: queues serial bits and the expected queued word
    task automatic send_word(input logic [8:0] w, input bit wide, input bit kept);
        for (int i = 0; i < (wide ? 9 : 8); i++) bitq.push_back(w[i]);
        if (kept) expq.push_back(wide ? w : {1'b0, w[7:0]});
    endtask

    task automatic wait_falls(input int n);
        int target;
        target = fall_cnt + n;
        while (fall_cnt < target) tick();
    endtask

    // monitor: compares queue head with scoreboard, then pops
    task automatic read_check(input string req);
        logic [8:0] e;
        e = (expq.size() != 0) ? expq.pop_front() : 9'h1FF;
        chk(data_avail == 1'b1, req, "avail before read", data_avail, 1);
        chk({rd_bit9, rd_data} == e, req, "read word", {rd_bit9, rd_data}, e);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic pulse_one_shot();
        one_shot_req = 1'b1;
        tick();
        one_shot_req = 1'b0;
    endtask

    initial begin
        while (!done_flag) begin
            @(posedge clk);
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        bit idle_ok;
        repeat (3) tick();
        chk(rx_sclk == 0 && data_avail == 0 && overrun == 0 && irq == 0,
            "R2", "reset state", {rx_sclk, data_avail, overrun, irq}, 0);
        rst_n = 1'b1;
        tick();

        // R3 single 8-bit word, divider 2, R1 lsb first
        div_val = 8'd2;
        send_word(9'h0A5, 0, 1);
        pulse_one_shot();
        wait_falls(8);
        tick();
        chk(rise_gap == 6, "R2", "shift clock period div2", rise_gap, 6);
        chk(one_shot_busy == 0, "R3", "one-shot clears", one_shot_busy, 0);
        chk(irq == 0, "R10", "irq masked", irq, 0);
        idle_ok = 1;
        for (int i = 0; i < 12; i++) begin
            if (rx_sclk) idle_ok = 0;
            tick();
        end
        chk(idle_ok, "R3", "clock idle after single word", idle_ok, 1);
        read_check("R1");
        chk(data_avail == 0, "R6", "empty after read", data_avail, 0);

        // R5 nine-bit words, divider 1
        div_val = 8'd1;
        nine_bit_en = 1'b1;
        irq_en = 1'b1;
        send_word(9'h13C, 1, 1);
        pulse_one_shot();
        wait_falls(9);
        tick();
        chk(rise_gap == 4, "R2", "shift clock period div1", rise_gap, 4);
        chk(irq == 1, "R10", "irq raised", irq, 1);
        read_check("R5");
        chk(irq == 0, "R10", "irq drops when empty", irq, 0);
        send_word(9'h0C3, 1, 1);
        pulse_one_shot();
        wait_falls(9);
        tick();
        read_check("R5");
        nine_bit_en = 1'b0;
        irq_en = 1'b0;

        // R4 continuous with one-shot also set: two words arrive
        send_word(9'h012, 0, 1);
        send_word(9'h0F0, 0, 1);
        cont_en = 1'b1;
        pulse_one_shot();
        wait_falls(16);
        tick();
        cont_en = 1'b0;
        tick();
        bitq.delete();
        chk(dut.data_avail == 1, "R4", "words after continuous run", data_avail, 1);
        read_check("R4");
        read_check("R6");
        chk(data_avail == 0, "R6", "empty after two reads", data_avail, 0);

        // R7 overrun with third word, R8 fourth word blocked, R9 clear
        repeat (4) tick();
        send_word(9'h055, 0, 1);
        send_word(9'h0AA, 0, 1);
        send_word(9'h0EE, 0, 0);
        send_word(9'h077, 0, 0);
        cont_en = 1'b1;
        wait_falls(24);
        tick();
        chk(overrun == 1, "R7", "overrun set", overrun, 1);
        read_check("R7");
        read_check("R7");
        wait_falls(8);
        tick();
        chk(data_avail == 0, "R8", "no transfer during overrun", data_avail, 0);
        chk(overrun == 1, "R9", "overrun held", overrun, 1);
        cont_en = 1'b0;
        tick();
        chk(overrun == 0, "R9", "overrun cleared", overrun, 0);
        bitq.delete();
        repeat (4) tick();

        // transfers resume after clear
        send_word(9'h081, 0, 1);
        pulse_one_shot();
        wait_falls(8);
        tick();
        read_check("R8");
        chk(expq.size() == 0, "R6", "scoreboard drained", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done_flag = 1;
        $finish;
    end
endmodule